// File: doc/BRIEF.md
# Watchdog Input Conditioner

This block sits in front of a window-watchdog state machine and turns three asynchronous, possibly bouncing input pins into clean, registered events. The three pins are a trigger (active low pulse), a mode select and a wake-up line. Each pin first passes through a two-flop synchronizer. A debounce counter then accepts a new level only after the synchronized value has differed from the current output for a full, per-pin number of cycles. Trigger and mode use a short count. Wake-up uses a much longer one.

From the debounced trigger the block derives two signals. The first is a single-cycle acceptance strobe, raised on each return to high. The second is an error level, raised when the trigger stays low longer than a configured limit. Over-length pulses never produce the acceptance strobe. From the debounced wake-up level the block emits a one-cycle strobe on every change, rising or falling. The watchdog state machine consumes all of these directly.

Top module: `wdog_input_cond`

## Requirements
- R1: While and after synchronous reset, with pins held at their idle levels, mode_d=1, trg_d=1, trg_ok=0, trg_err=0 and wedge=0. The internal debounced wake-up level resets to 0.
- R2: When trg_raw changes level before clock edge 1 and holds for L edges, trg_d takes the new level at edge TRG_DEB+2 if L >= TRG_DEB. A trigger pulse with L < TRG_DEB leaves trg_d, trg_ok and trg_err unchanged.
- R3: mode_raw is debounced the same way with MODE_DEB. Its new level appears on mode_d at edge MODE_DEB+2, and shorter pulses have no effect on mode_d.
- R4: wup_raw is debounced with WUP_DEB. A pulse shorter than WUP_DEB edges produces no wedge.
- R5: wedge is high for exactly one cycle, in the same cycle the debounced wake-up level changes, for both rising and falling changes.
- R6: trg_ok is high for exactly one cycle, in the same cycle trg_d returns high, provided trg_d was low for at most TRG_MAX_LOW cycles.
- R7: trg_err rises once trg_d has been sampled low for TRG_MAX_LOW+1 cycles. It stays high until the cycle after trg_d returns high.
- R8: A low period of trg_d longer than TRG_MAX_LOW produces no trg_ok, and trg_ok and trg_err are never high together.
- R9: Any mismatch-free interruption of the count restarts it. A pin that returns to the output level before the count completes leaves the output unchanged, even if the total time away exceeds the debounce length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trg_raw | input | 1 | Raw trigger pin, active-low pulse, idle high |
| mode_raw | input | 1 | Raw mode pin, idle high |
| wup_raw | input | 1 | Raw wake-up pin, idle low |
| mode_d | output | 1 | Debounced mode level |
| trg_d | output | 1 | Debounced trigger level |
| trg_ok | output | 1 | One-cycle strobe for an accepted trigger pulse |
| trg_err | output | 1 | Trigger held low too long |
| wedge | output | 1 | One-cycle strobe on any debounced wake-up change |

## Verification
Two trigger-path functions can land on the same clock edge. When the raw low pulse lasts exactly TRG_MAX_LOW+1 cycles, the edge that returns trg_d high is also the edge on which the error becomes due. The bench provokes this by sweeping the trigger low length through every value from one cycle up to a few cycles past the limit. At that boundary length it requires that trg_err is raised and that no trg_ok appears, while at one cycle shorter it requires exactly one trg_ok and no error.

// File: rtl/wic_pkg.sv
package wic_pkg;

  typedef enum logic [1:0] {
    CH_TRG  = 2'd0,
    CH_MODE = 2'd1,
    CH_WUP  = 2'd2
  } wic_chan_e;

  localparam int NUM_CH = 3;

  // bits needed to hold the value maxval
  function automatic int width_for(input int maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

  // edge (counted from the first edge seeing the raw change) at which the
  // debounced level flips: two synchronizer stages plus len counting edges
  function automatic int flip_edge(input int len);
    return len + 2;
  endfunction

endpackage

// File: rtl/wic_sync.sv
module wic_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic sync_o
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= raw_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/wic_debounce.sv
module wic_debounce #(
  parameter int   LEN     = 4,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_i,
  output logic level_o,
  output logic flip_o
);
  localparam int CW = wic_pkg::width_for(LEN - 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          level_q;
  logic          differs;

  assign differs = (samp_i != level_q);
  assign flip_o  = differs && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      level_q <= RST_VAL;
    end else if (!differs) begin
      cnt_q   <= '0;
    end else if (flip_o) begin
      cnt_q   <= '0;
      level_q <= samp_i;
    end else begin
      cnt_q   <= cnt_q + CW'(1);
    end
  end

  assign level_o = level_q;

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(level_o) |-> $past(samp_i) != $past(level_o));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/wic_trig_police.sv
module wic_trig_police #(
  parameter int MAX_LOW = 45
) (
  input  logic clk,
  input  logic rst,
  input  logic trg_d_i,
  input  logic rise_i,
  output logic ok_o,
  output logic err_o
);
  localparam int LW = wic_pkg::width_for(MAX_LOW);
  localparam logic [LW-1:0] LIMIT = LW'(MAX_LOW);

  logic [LW-1:0] low_cnt_q;
  logic          err_q;
  logic          ok_q;
  logic          err_set;

  assign err_set = !trg_d_i && (low_cnt_q == LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt_q <= '0;
      err_q     <= 1'b0;
      ok_q      <= 1'b0;
    end else begin
      if (trg_d_i)
        low_cnt_q <= '0;
      else if (low_cnt_q != LIMIT)
        low_cnt_q <= low_cnt_q + LW'(1);

      if (trg_d_i)
        err_q <= 1'b0;
      else if (err_set)
        err_q <= 1'b1;

      ok_q <= rise_i && !err_q && !err_set;
    end
  end

  assign ok_o  = ok_q;
  assign err_o = err_q;

  // R6
  ok_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ok_o |=> !ok_o);

  // R8
  ok_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ok_o && err_o));

  // R7
  err_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> $past(!trg_d_i));
endmodule

// File: rtl/wdog_input_cond.sv
module wdog_input_cond #(
  parameter int TRG_DEB     = 4,
  parameter int MODE_DEB    = 4,
  parameter int WUP_DEB     = 112,
  parameter int TRG_MAX_LOW = 45
) (
  input  logic clk,
  input  logic rst,
  input  logic trg_raw,
  input  logic mode_raw,
  input  logic wup_raw,
  output logic mode_d,
  output logic trg_d,
  output logic trg_ok,
  output logic trg_err,
  output logic wedge
);
  import wic_pkg::*;

  logic [NUM_CH-1:0] raw_vec;
  logic [NUM_CH-1:0] sync_vec;
  logic [NUM_CH-1:0] level_vec;
  logic [NUM_CH-1:0] flip_vec;

  assign raw_vec[CH_TRG]  = trg_raw;
  assign raw_vec[CH_MODE] = mode_raw;
  assign raw_vec[CH_WUP]  = wup_raw;

  for (genvar g = 0; g < NUM_CH; g++) begin : ch_g
    localparam int   LEN = (g == int'(CH_TRG))  ? TRG_DEB :
                           (g == int'(CH_MODE)) ? MODE_DEB : WUP_DEB;
    localparam logic RV  = (g == int'(CH_WUP)) ? 1'b0 : 1'b1;

    wic_sync #(.RST_VAL(RV)) sync_i (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw_vec[g]),
      .sync_o (sync_vec[g])
    );

    wic_debounce #(.LEN(LEN), .RST_VAL(RV)) deb_i (
      .clk     (clk),
      .rst     (rst),
      .samp_i  (sync_vec[g]),
      .level_o (level_vec[g]),
      .flip_o  (flip_vec[g])
    );
  end

  logic trg_rise;
  logic wup_level;
  logic wedge_q;

  assign trg_rise  = flip_vec[CH_TRG] && !level_vec[CH_TRG];
  assign wup_level = level_vec[CH_WUP];

  wic_trig_police #(.MAX_LOW(TRG_MAX_LOW)) police_i (
    .clk     (clk),
    .rst     (rst),
    .trg_d_i (level_vec[CH_TRG]),
    .rise_i  (trg_rise),
    .ok_o    (trg_ok),
    .err_o   (trg_err)
  );

  always_ff @(posedge clk) begin
    if (rst) wedge_q <= 1'b0;
    else     wedge_q <= flip_vec[CH_WUP];
  end

  assign mode_d = level_vec[CH_MODE];
  assign trg_d  = level_vec[CH_TRG];
  assign wedge  = wedge_q;

  // R5
  wedge_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    wedge |-> !$stable(wup_level));

  // R5
  change_gives_wedge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wup_level) |-> wedge);

  // R6
  ok_with_high_chk: assert property (@(posedge clk) disable iff (rst)
    trg_ok |-> (trg_d && $rose(trg_d)));
endmodule

// File: tb/wdog_input_cond_tb_top.sv
module wdog_input_cond_tb_top;
  localparam int TDEB = 3;
  localparam int MDEB = 4;
  localparam int WDEB = 8;
  localparam int TMAX = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trg_raw = 1'b1;
  logic mode_raw = 1'b1;
  logic wup_raw = 1'b0;
  logic mode_d, trg_d, trg_ok, trg_err, wedge;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wdog_input_cond #(
    .TRG_DEB(TDEB), .MODE_DEB(MDEB), .WUP_DEB(WDEB), .TRG_MAX_LOW(TMAX)
  ) dut_i (
    .clk(clk), .rst(rst), .trg_raw(trg_raw), .mode_raw(mode_raw),
    .wup_raw(wup_raw), .mode_d(mode_d), .trg_d(trg_d), .trg_ok(trg_ok),
    .trg_err(trg_err), .wedge(wedge)
  );

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // trigger low pulse of L edges; observation index k = edges since drop
  task automatic run_trg(input int len);
    int fall_at = -1, rise_at = -1, ok_n = 0, ok_at = -1;
    int err_first = -1, err_last = -1;
    int total = len + TMAX + 12;
    bit exp_pass = (len >= TDEB);
    bit exp_err = (len > TMAX) && exp_pass;
    @(negedge clk);
    trg_raw = 1'b0;
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      if (!trg_d && fall_at < 0) fall_at = k;
      if (trg_d && fall_at >= 0 && rise_at < 0) rise_at = k;
      if (trg_ok) begin ok_n++; ok_at = k; end
      if (trg_err) begin if (err_first < 0) err_first = k; err_last = k; end
      if (k == len) trg_raw = 1'b1;
    end
    if (!exp_pass) begin
      // R2 short pulse swallowed
      chk(fall_at < 0, "R2", $sformatf("short trg L=%0d fall", len), fall_at, -1);
      chk(ok_n == 0 && err_first < 0, "R2", $sformatf("short trg L=%0d events", len),
          ok_n, 0);
    end else begin
      chk(fall_at == TDEB + 2, "R2", $sformatf("trg L=%0d fall edge", len),
          fall_at, TDEB + 2);
      chk(rise_at == len + TDEB + 2, "R2", $sformatf("trg L=%0d rise edge", len),
          rise_at, len + TDEB + 2);
      if (!exp_err) begin
        chk(ok_n == 1, "R6", $sformatf("ok count L=%0d", len), ok_n, 1);
        chk(ok_at == len + TDEB + 2, "R6", $sformatf("ok edge L=%0d", len),
            ok_at, len + TDEB + 2);
        chk(err_first < 0, "R7", $sformatf("no err L=%0d", len), err_first, -1);
      end else begin
        chk(ok_n == 0, "R8", $sformatf("ok suppressed L=%0d", len), ok_n, 0);
        chk(err_first == TDEB + TMAX + 3, "R7", $sformatf("err rise L=%0d", len),
            err_first, TDEB + TMAX + 3);
        chk(err_last == len + TDEB + 2, "R7", $sformatf("err last L=%0d", len),
            err_last, len + TDEB + 2);
      end
    end
  endtask

  task automatic run_mode(input int len);
    int fall_at = -1, rise_at = -1;
    int total = len + MDEB + 8;
    @(negedge clk);
    mode_raw = 1'b0;
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      if (!mode_d && fall_at < 0) fall_at = k;
      if (mode_d && fall_at >= 0 && rise_at < 0) rise_at = k;
      if (k == len) mode_raw = 1'b1;
    end
    if (len < MDEB) begin
      chk(fall_at < 0, "R3", $sformatf("short mode L=%0d", len), fall_at, -1);
    end else begin
      chk(fall_at == MDEB + 2, "R3", $sformatf("mode L=%0d fall", len),
          fall_at, MDEB + 2);
      chk(rise_at == len + MDEB + 2, "R3", $sformatf("mode L=%0d rise", len),
          rise_at, len + MDEB + 2);
    end
  endtask

  task automatic run_wup(input int len);
    int n = 0, first = -1, second = -1;
    int total = len + WDEB + 8;
    @(negedge clk);
    wup_raw = 1'b1;
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      if (wedge) begin
        n++;
        if (first < 0) first = k; else second = k;
      end
      if (k == len) wup_raw = 1'b0;
    end
    if (len < WDEB) begin
      chk(n == 0, "R4", $sformatf("short wup L=%0d", len), n, 0);
    end else begin
      chk(n == 2, "R5", $sformatf("wedge count L=%0d", len), n, 2);
      chk(first == WDEB + 2, "R5", $sformatf("rising wedge L=%0d", len),
          first, WDEB + 2);
      chk(second == len + WDEB + 2, "R5", $sformatf("falling wedge L=%0d", len),
          second, len + WDEB + 2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 values during reset
    chk(mode_d && trg_d && !trg_ok && !trg_err && !wedge, "R1", "in reset",
        {mode_d, trg_d, trg_ok, trg_err, wedge}, 5'b11000);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(mode_d && trg_d && !trg_ok && !trg_err && !wedge, "R1", "after reset",
        {mode_d, trg_d, trg_ok, trg_err, wedge}, 5'b11000);

    for (int len = 1; len <= TMAX + 4; len++) run_trg(len);
    for (int len = 1; len <= MDEB + 3; len++) run_mode(len);
    for (int len = 1; len <= WDEB + 3; len++) run_wup(len);

    // R9 bouncing trigger: low 2, high 1, low 2 never reaches TDEB in a row
    begin
      int seen = 0;
      int pat[6] = '{0, 0, 1, 0, 0, 1};
      foreach (pat[i]) begin
        @(negedge clk);
        trg_raw = pat[i][0];
        if (!trg_d || trg_ok) seen++;
      end
      repeat (12) begin
        @(negedge clk);
        if (!trg_d || trg_ok || trg_err) seen++;
      end
      chk(seen == 0, "R9", "bounced trigger ignored", seen, 0);
    end
    // R9 bouncing wake-up: WDEB-1 high, 1 low, WDEB-1 high
    begin
      int seen = 0;
      for (int i = 0; i < 2 * WDEB + 12; i++) begin
        @(negedge clk);
        if (wedge) seen++;
        wup_raw = (i < WDEB - 1) || (i >= WDEB && i < 2 * WDEB - 1);
      end
      chk(seen == 0, "R9", "bounced wake-up ignored", seen, 0);
    end

    repeat (4) @(negedge clk);
    summary();
  end
endmodule